// File: doc/BRIEF.md
# Transition-Encoded Clockless Command Link

This block moves 4-bit commands from one clock domain to another without sending any clock or strobe alongside the data. The link is sixteen wires wide, one wire for each possible command value. The sending half decodes an accepted command into a single-wire mask and flips the level of that wire only. Every transfer therefore changes exactly one wire, and no qualifying clock is needed to tell a complete word from one that is still settling.

The receiving half runs on its own unrelated clock. It passes every incoming wire through a two-flop synchronizer and compares the result with a stored copy of the last bus value it accepted. When exactly one wire differs, it turns that wire's position back into the command and raises a one-cycle valid pulse. When several wires differ in the same receive cycle, it raises a one-cycle error and adopts the current bus value as its new reference.

The sender stays busy for a set number of its own clocks after each accepted command, so that two toggles reach the receiver far enough apart to be seen separately. The wires leave the block on one port and come back in on another, so that the board, or a bench, sits between the two halves.

Top module: `toggle_cmd_link`

## Requirements
- R1: While either reset is low, and after both are released before any command, `link_out` is all zeros, `busy` is low, and `cmd_valid` and `err` are low.
- R2: A command is accepted on a rising `tx_clk` edge where `send` is high and `busy` is low. After that edge, `link_out` differs from its earlier value in exactly one bit, bit number `cmd_in` (bit i carries command value i, bit 0 is the least significant). The first command after reset drives its wire from 0 to 1.
- R3: After an accepted command, `busy` is high for exactly `HOLD_CYCLES` rising `tx_clk` edges (default 4). A `send` raised while `busy` is high is ignored: `link_out` does not change and nothing is reported at the receiver.
- R4: When exactly one bit of `link_in` changes, `cmd_out` takes that bit's index and `cmd_valid` is high for exactly one `rx_clk` cycle, no later than the fourth falling `rx_clk` edge after the change (two synchronizer stages plus one output register). `err` stays low.
- R5: Sending the same command twice in a row toggles its wire back to its former level, and both transfers are reported as that command.
- R6: When two or more bits of `link_in` change within one receive cycle, `err` is high for one `rx_clk` cycle, `cmd_valid` stays low, and the receiver takes the new bus value as its reference, so that the next single-wire change is decoded normally.
- R7: Commands 0 and 15 map to the lowest and highest wires, and `cmd_out` holds the last reported command between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Sending-side clock |
| tx_rst_n | input | 1 | Sending-side asynchronous active-low reset, released synchronously inside |
| send | input | 1 | Request to send `cmd_in` |
| cmd_in | input | 4 | Command to send |
| busy | output | 1 | High while the sender refuses new commands |
| link_out | output | 16 | Level of each link wire as driven by the sender |
| rx_clk | input | 1 | Receiving-side clock, unrelated to `tx_clk` |
| rx_rst_n | input | 1 | Receiving-side asynchronous active-low reset, released synchronously inside |
| link_in | input | 16 | Link wires as they arrive at the receiver |
| cmd_out | output | 4 | Last decoded command |
| cmd_valid | output | 1 | One-cycle pulse marking a newly decoded command |
| err | output | 1 | One-cycle pulse marking more than one wire changed at once |

## Verification
The hardest state to reach is a receive cycle in which several wires differ from the reference at once, since a correct sender never produces it. The bench places an XOR mask between `link_out` and `link_in` and flips two wires of it together while the link is idle, then checks the error pulse and that a following real command still decodes. It also raises `send` repeatedly inside the busy window and watches both `link_out` and the receiver's pulse count to show the requests left no trace.

// File: rtl/tclink_pkg.sv
package tclink_pkg;

  localparam int unsigned DEF_CMD_W = 4;
  localparam int unsigned DEF_HOLD  = 4;

  // What the receiver saw when comparing synchronized wires with its reference
  typedef enum logic [1:0] {
    RX_QUIET = 2'd0,
    RX_ONE   = 2'd1,
    RX_MANY  = 2'd2
  } rx_kind_e;

endpackage

// File: rtl/tclink_rst_sync.sv
module tclink_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_s = out_q;

endmodule

// File: rtl/tclink_bit_sync.sv
module tclink_bit_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_wire
    logic meta_q;
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        held_q <= 1'b0;
      end else begin
        meta_q <= d_async[g];
        held_q <= meta_q;
      end
    end

    assign q_sync[g] = held_q;
  end

endmodule

// File: rtl/tclink_tx.sv
module tclink_tx #(
  parameter int unsigned CMD_W       = tclink_pkg::DEF_CMD_W,
  parameter int unsigned HOLD_CYCLES = tclink_pkg::DEF_HOLD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send,
  input  logic [CMD_W-1:0]     cmd_in,
  output logic                 busy,
  output logic [(1<<CMD_W)-1:0] wires
);

  localparam int unsigned NW    = 1 << CMD_W;
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [NW-1:0]    lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic             lvl_en, cnt_en;

  assign busy   = (cnt_q != '0);
  assign accept = send && !busy;

  // next state
  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    lvl_en = accept;
    cnt_en = accept || busy;
    if (accept) begin
      lvl_d = lvl_q ^ (NW'(1) << cmd_in);
      cnt_d = CNT_W'(HOLD_CYCLES);
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (lvl_en) lvl_q <= lvl_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign wires = lvl_q;

  p_one_wire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_q ^ $past(lvl_q)) <= 1);

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !busy) |=> busy);

  p_busy_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lvl_q));

endmodule

// File: rtl/tclink_rx.sv
module tclink_rx #(
  parameter int unsigned CMD_W = tclink_pkg::DEF_CMD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<CMD_W)-1:0] wires_s,
  output logic [CMD_W-1:0]      cmd_out,
  output logic                  cmd_valid,
  output logic                  err
);

  import tclink_pkg::*;

  localparam int unsigned NW = 1 << CMD_W;

  logic [NW-1:0]    ref_q, ref_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             vld_q, vld_d;
  logic             err_q, err_d;
  logic [NW-1:0]    diff;
  logic [CMD_W-1:0] idx;
  rx_kind_e         kind;
  logic             ref_en;

  assign diff = wires_s ^ ref_q;

  // classify the difference
  always_comb begin
    if (diff == '0)
      kind = RX_QUIET;
    else if ((diff & (diff - NW'(1))) == '0)
      kind = RX_ONE;
    else
      kind = RX_MANY;
  end

  // position of the changed wire
  always_comb begin
    idx = '0;
    for (int i = 0; i < NW; i++) begin
      if (diff[i]) idx = CMD_W'(i);
    end
  end

  // next state
  always_comb begin
    ref_d  = ref_q;
    cmd_d  = cmd_q;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    ref_en = (kind != RX_QUIET);
    unique case (kind)
      RX_ONE: begin
        ref_d = wires_s;
        cmd_d = idx;
        vld_d = 1'b1;
      end
      RX_MANY: begin
        ref_d = wires_s;
        err_d = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      cmd_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ref_en) ref_q <= ref_d;
      if (vld_d)  cmd_q <= cmd_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign cmd_out   = cmd_q;
  assign cmd_valid = vld_q;
  assign err       = err_q;

  p_single_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(diff) |=> (cmd_valid && !err));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (diff == '0) |=> (!cmd_valid && !err));

  p_multi_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(diff) > 1) |=> (err && !cmd_valid));

  p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_out));

endmodule

// File: rtl/toggle_cmd_link.sv
module toggle_cmd_link #(
  parameter int unsigned CMD_W       = tclink_pkg::DEF_CMD_W,
  parameter int unsigned HOLD_CYCLES = tclink_pkg::DEF_HOLD
) (
  input  logic                  tx_clk,
  input  logic                  tx_rst_n,
  input  logic                  send,
  input  logic [CMD_W-1:0]      cmd_in,
  output logic                  busy,
  output logic [(1<<CMD_W)-1:0] link_out,
  input  logic                  rx_clk,
  input  logic                  rx_rst_n,
  input  logic [(1<<CMD_W)-1:0] link_in,
  output logic [CMD_W-1:0]      cmd_out,
  output logic                  cmd_valid,
  output logic                  err
);

  localparam int unsigned NW = 1 << CMD_W;

  logic          tx_rst_s;
  logic          rx_rst_s;
  logic [NW-1:0] rx_wires;

  tclink_rst_sync u_tx_rst (
    .clk     (tx_clk),
    .arst_n  (tx_rst_n),
    .rst_n_s (tx_rst_s)
  );

  tclink_rst_sync u_rx_rst (
    .clk     (rx_clk),
    .arst_n  (rx_rst_n),
    .rst_n_s (rx_rst_s)
  );

  tclink_tx #(
    .CMD_W       (CMD_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_tx (
    .clk    (tx_clk),
    .rst_n  (tx_rst_s),
    .send   (send),
    .cmd_in (cmd_in),
    .busy   (busy),
    .wires  (link_out)
  );

  tclink_bit_sync #(
    .WIDTH (NW)
  ) u_sync (
    .clk     (rx_clk),
    .rst_n   (rx_rst_s),
    .d_async (link_in),
    .q_sync  (rx_wires)
  );

  tclink_rx #(
    .CMD_W (CMD_W)
  ) u_rx (
    .clk       (rx_clk),
    .rst_n     (rx_rst_s),
    .wires_s   (rx_wires),
    .cmd_out   (cmd_out),
    .cmd_valid (cmd_valid),
    .err       (err)
  );

endmodule

// File: tb/toggle_cmd_link_test.sv
`timescale 1ns/1ps
module toggle_cmd_link_test;

  localparam int HOLD = 4;
  localparam int NV   = 12;
  // each entry: {command sent, command expected at the receiver}
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'hFF, 8'h77, 8'h77, 8'h11, 8'h88,
    8'h33, 8'h33, 8'h33, 8'hCC, 8'h55, 8'hAA
  };

  logic        tx_clk = 1'b0;
  logic        rx_clk = 1'b0;
  logic        tx_rst_n;
  logic        rx_rst_n;
  logic        send;
  logic [3:0]  cmd_in;
  logic        busy;
  logic [15:0] link_out;
  logic [15:0] link_in;
  logic [15:0] inj;
  logic [3:0]  cmd_out;
  logic        cmd_valid;
  logic        err;

  int checks = 0;
  int errs   = 0;
  int vcount = 0;
  int ecount = 0;
  logic [3:0]  last_cmd = 4'd0;
  logic [15:0] exp_bus  = 16'h0;
  bit done = 1'b0;

  always #10 tx_clk = ~tx_clk;
  always #18.5 rx_clk = ~rx_clk;

  assign link_in = link_out ^ inj;

  toggle_cmd_link #(.CMD_W(4), .HOLD_CYCLES(HOLD)) uut (
    .tx_clk    (tx_clk),
    .tx_rst_n  (tx_rst_n),
    .send      (send),
    .cmd_in    (cmd_in),
    .busy      (busy),
    .link_out  (link_out),
    .rx_clk    (rx_clk),
    .rx_rst_n  (rx_rst_n),
    .link_in   (link_in),
    .cmd_out   (cmd_out),
    .cmd_valid (cmd_valid),
    .err       (err)
  );

  // port monitor: counts pulses away from the active edge
  always @(negedge rx_clk) begin
    if (cmd_valid) begin
      vcount   <= vcount + 1;
      last_cmd <= cmd_out;
    end
    if (err) ecount <= ecount + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_send(input logic [3:0] c);
    @(negedge tx_clk);
    while (busy) @(negedge tx_clk);
    send   = 1'b1;
    cmd_in = c;
    @(negedge tx_clk);
    send    = 1'b0;
    exp_bus = exp_bus ^ (16'h1 << c);
  endtask

  task automatic rx_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rx_clk);
  endtask

  task automatic apply_reset();
    tx_rst_n = 1'b0;
    rx_rst_n = 1'b0;
    send     = 1'b0;
    cmd_in   = 4'd0;
    inj      = 16'h0;
    exp_bus  = 16'h0;
    #95;
    chk(link_out == 16'h0, "R1 link during reset", link_out, 0);
    chk(!busy && !cmd_valid && !err, "R1 flags during reset",
        {busy, cmd_valid, err}, 0);
    tx_rst_n = 1'b1;
    rx_rst_n = 1'b1;
    rx_wait(4);
    chk(link_out == 16'h0, "R1 link after reset", link_out, 0);
    chk(!busy && !cmd_valid && !err, "R1 flags after reset",
        {busy, cmd_valid, err}, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int base_v;
    int base_e;
    int nb;
    int lat;
    logic [3:0] prev;
    apply_reset();

    // table walk
    prev = 4'hx;
    for (int k = 0; k < NV; k++) begin
      logic [3:0] c;
      logic [3:0] e;
      c = VEC[k][7:4];
      e = VEC[k][3:0];
      base_e = ecount;
      do_send(c);
      chk(link_out == exp_bus, (prev === c) ? "R5 wire toggled back" : "R2 single wire",
          link_out, exp_bus);
      if (k == 0)
        chk(link_out == 16'h0001, "R2 first command 0->1", link_out, 16'h0001);
      lat = 0;
      for (int i = 1; i <= 8; i++) begin
        @(negedge rx_clk);
        if (cmd_valid) begin
          lat = i;
          break;
        end
      end
      chk(lat >= 1 && lat <= 4, "R4 latency", lat, 4);
      chk(cmd_out == e, (prev === c) ? "R5 repeat reported" :
          ((c == 4'd0 || c == 4'd15) ? "R7 edge wire" : "R4 decode"), cmd_out, e);
      @(negedge rx_clk);
      chk(!cmd_valid, "R4 one-cycle pulse", cmd_valid, 0);
      rx_wait(3);
      chk(cmd_out == e, "R7 cmd_out holds", cmd_out, e);
      chk(ecount == base_e, "R4 no error", ecount - base_e, 0);
      prev = c;
    end

    // busy window and ignored requests
    base_v = vcount;
    do_send(4'd2);
    nb = 0;
    for (int i = 0; i < 8; i++) begin
      if (busy) nb++;
      send   = (i >= 1 && i <= 2);
      cmd_in = 4'd11;
      @(negedge tx_clk);
      send = 1'b0;
      chk(link_out == exp_bus, "R3 send while busy ignored", link_out, exp_bus);
    end
    chk(nb == HOLD, "R3 busy length", nb, HOLD);
    rx_wait(10);
    chk(vcount - base_v == 1, "R3 single report", vcount - base_v, 1);
    chk(last_cmd == 4'd2, "R3 reported command", last_cmd, 2);

    // two wires change at once
    base_v = vcount;
    base_e = ecount;
    @(negedge rx_clk);
    inj = 16'h0300;
    rx_wait(6);
    chk(ecount - base_e == 1, "R6 error pulse", ecount - base_e, 1);
    chk(vcount == base_v, "R6 no valid on error", vcount - base_v, 0);
    do_send(4'd3);
    rx_wait(8);
    chk(vcount - base_v == 1 && last_cmd == 4'd3, "R6 recovery decode", last_cmd, 3);
    chk(ecount - base_e == 1, "R6 no extra error", ecount - base_e, 1);
    @(negedge rx_clk);
    inj = 16'h0000;
    rx_wait(6);
    chk(ecount - base_e == 2, "R6 second error", ecount - base_e, 2);

    // reset after traffic, then highest wire first
    apply_reset();
    base_v = vcount;
    do_send(4'd15);
    chk(link_out == 16'h8000, "R2 first after reset", link_out, 16'h8000);
    rx_wait(8);
    chk(vcount - base_v == 1 && last_cmd == 4'd15, "R7 top wire", last_cmd, 15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule